// File: doc/BRIEF.md
# Shadowed Nonvolatile I/O Register Bank

This block is the byte-addressed register file behind a nine-pin open-drain I/O expander. A host port carries an address, write data, a write strobe and a read strobe. An I2C target front end is expected to drive that port. The front end is not part of this block. The block only forms the 7-bit device address that the front end compares against. The bank holds persistent user bytes, reserved ranges, pullup and pulldown control for each pin, a configuration register, read-only pin level registers and volatile scratch bytes.

The persistent store is an internal array. Its contents survive the block reset and start at fixed defaults. The five control registers at 0xF0 to 0xF4 each have two copies: a live shadow copy that drives the pins, and a persistent copy. A protect bit in the configuration register selects whether a control write reaches the shadow copy only or both copies. Reset reloads every shadow copy from its persistent copy. The block outputs one pulldown enable and one pullup enable per pin.

Top module: `ioxRegBank`

## Requirements
- R1: Addresses 0x00 to 0x3F are persistent user bytes. They read back the last value written, default to 0x00, and accept writes whatever the protect bit holds.
- R2: Writes to addresses 0x40 to 0xEF have no effect. Reads from those addresses return 0x00.
- R3: pullUpEn[7:0] follows the shadow of 0xF0, with pin 0 at bit 0, and pullUpEn[8] follows bit 0 of 0xF1. Both registers default to 0x00. The upper seven bits of 0xF1 read as 0.
- R4: A 0 in bit i of 0xF2 (pins 0 to 7), or in bit 0 of 0xF3 (pin 8), sets pullDownEn for that pin to 1. A 1 releases the pin. The defaults are 0xFF and 0x01. The upper seven bits of 0xF3 and of 0xF4 read as 0.
- R5: Bit 0 of 0xF4 is the protect bit, and its value before a write decides that write. While it is 1, a write to 0xF0 to 0xF4 changes only the shadow copy. While it is 0, the write changes both copies.
- R6: Reset loads each of 0xF0 to 0xF4 from its persistent copy. Persistent contents, including the user bytes, survive reset.
- R7: Addresses 0xF5 to 0xF7 are three more persistent user bytes. They behave as in R1.
- R8: 0xF8 returns the levels of pins 0 to 7. 0xF9 returns pin 8 in bit 0 and zeros above it. Each level passes through two flops first. Writes to 0xF8 and 0xF9 have no effect.
- R9: Addresses 0xFA to 0xFF are six volatile scratch bytes. They read back what was written and read 0x00 after reset.
- R10: devAddr equals binary 1010 followed by strapAddr[2:0].
- R11: hostRdata changes only on the clock edge that samples hostRd high. It then holds the addressed value as it stood before any write in the same cycle. It reads 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapAddr | input | 3 | Address strap inputs, low three device-address bits |
| devAddr | output | 7 | Device address for the bus front end to match |
| hostAddr | input | 8 | Register byte address |
| hostWdata | input | 8 | Write data |
| hostWr | input | 1 | Write strobe, one cycle per write |
| hostRd | input | 1 | Read strobe, one cycle per read |
| hostRdata | output | 8 | Registered read data |
| pinIn | input | 9 | Asynchronous pin levels |
| pullUpEn | output | 9 | Pullup enable per pin |
| pullDownEn | output | 9 | Pulldown (drive low) enable per pin |

## Verification
The assertions assume that the host strobes are synchronous to clk and that hostAddr stays within 8 bits. They also assume that a write or read is presented only while rstN is high. The stimulus changes every host input on the falling edge and holds it for exactly one rising edge. It drops the strobes before any reset is applied. pinIn changes only on the falling edge, and the bench waits at least three cycles before reading the level registers. Each shadow, protect and reset check therefore sees a defined synchronizer state.

// File: rtl/ioxRegPkg.sv
package ioxRegPkg;

  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 8;
  localparam int PIN_CNT     = 9;
  localparam int LOW_USER    = 64;
  localparam int HIGH_USER   = 3;
  localparam int NV_USER     = LOW_USER + HIGH_USER;
  localparam int SHADOW_CNT  = 5;
  localparam int SCRATCH_CNT = 6;
  localparam int USER_IDX_W  = $clog2(NV_USER);
  localparam int SHADOW_IDX_W  = $clog2(SHADOW_CNT);
  localparam int SCRATCH_IDX_W = $clog2(SCRATCH_CNT);

  // Address map boundaries (decode order matters)
  localparam logic [ADDR_W-1:0] BASE_RESERVED = 8'h40;
  localparam logic [ADDR_W-1:0] BASE_SHADOW   = 8'hF0;
  localparam logic [ADDR_W-1:0] BASE_HIUSER   = 8'hF5;
  localparam logic [ADDR_W-1:0] BASE_STATUS   = 8'hF8;
  localparam logic [ADDR_W-1:0] BASE_SCRATCH  = 8'hFA;

  // Shadowed register slots
  localparam int SH_PULLUP_LO = 0;
  localparam int SH_PULLUP_HI = 1;
  localparam int SH_DRIVE_LO  = 2;
  localparam int SH_DRIVE_HI  = 3;
  localparam int SH_CFG       = 4;

  typedef logic [SHADOW_CNT-1:0][DATA_W-1:0] shadowBank_t;

  typedef enum logic [2:0] {
    RD_ZERO, RD_USER, RD_SHADOW, RD_STATUS, RD_SCRATCH
  } rdSel_e;

  typedef struct packed {
    logic                     userWr;
    logic                     shadowWr;
    logic                     nvWr;
    logic                     scratchWr;
    logic                     rdEn;
    rdSel_e                   rdSel;
    logic [USER_IDX_W-1:0]    userIdx;
    logic [SHADOW_IDX_W-1:0]  shadowIdx;
    logic                     statusIdx;
    logic [SCRATCH_IDX_W-1:0] scratchIdx;
  } ctlStrobe_t;

  // Single-pin registers keep only bit 0
  function automatic logic [DATA_W-1:0] shadowMask(int idx);
    return (idx == SH_PULLUP_HI || idx == SH_DRIVE_HI || idx == SH_CFG) ?
           DATA_W'(1) : {DATA_W{1'b1}};
  endfunction

  function automatic shadowBank_t shadowInit();
    shadowBank_t bank;
    for (int i = 0; i < SHADOW_CNT; i++) bank[i] = '0;
    bank[SH_DRIVE_LO] = {DATA_W{1'b1}};
    bank[SH_DRIVE_HI] = DATA_W'(1);
    return bank;
  endfunction

endpackage

// File: rtl/ioxRegCtrl.sv
module ioxRegCtrl
  import ioxRegPkg::*;
(
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              cfgProtect,
  output ctlStrobe_t        ctl
);

  always_comb begin
    ctl       = '0;
    ctl.rdSel = RD_ZERO;
    ctl.rdEn  = hostRd;
    if (hostAddr < BASE_RESERVED) begin
      ctl.rdSel   = RD_USER;
      ctl.userWr  = hostWr;
      ctl.userIdx = USER_IDX_W'(hostAddr);
    end else if (hostAddr < BASE_SHADOW) begin
      ctl.rdSel = RD_ZERO;
    end else if (hostAddr < BASE_HIUSER) begin
      ctl.rdSel     = RD_SHADOW;
      ctl.shadowWr  = hostWr;
      ctl.nvWr      = hostWr && !cfgProtect;
      ctl.shadowIdx = SHADOW_IDX_W'(hostAddr - BASE_SHADOW);
    end else if (hostAddr < BASE_STATUS) begin
      ctl.rdSel   = RD_USER;
      ctl.userWr  = hostWr;
      ctl.userIdx = USER_IDX_W'(LOW_USER) + USER_IDX_W'(hostAddr - BASE_HIUSER);
    end else if (hostAddr < BASE_SCRATCH) begin
      ctl.rdSel     = RD_STATUS;
      ctl.statusIdx = hostAddr[0];
    end else begin
      ctl.rdSel      = RD_SCRATCH;
      ctl.scratchWr  = hostWr;
      ctl.scratchIdx = SCRATCH_IDX_W'(hostAddr - BASE_SCRATCH);
    end
  end

endmodule

// File: rtl/ioxRegData.sv
module ioxRegData
  import ioxRegPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         ctl,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic [DATA_W-1:0]  hostRdata,
  output logic [PIN_CNT-1:0] pullUpEn,
  output logic [PIN_CNT-1:0] pullDownEn,
  output logic               cfgProtect
);

  logic [DATA_W-1:0] nvUser [NV_USER] = '{default: '0};
  shadowBank_t       nvShadow = shadowInit();
  shadowBank_t       shadow;
  logic [SCRATCH_CNT-1:0][DATA_W-1:0] scratch;
  logic [PIN_CNT-1:0] pinMeta;
  logic [PIN_CNT-1:0] pinSync;
  logic [DATA_W-1:0]  rdNext;

  // Persistent user bytes: untouched by reset
  always_ff @(posedge clk) begin
    if (rstN && ctl.userWr) nvUser[ctl.userIdx] <= hostWdata;
  end

  // Persistent and shadow copies of the control registers
  always_ff @(posedge clk) begin
    for (int i = 0; i < SHADOW_CNT; i++) begin
      if (rstN && ctl.nvWr && ctl.shadowIdx == SHADOW_IDX_W'(i))
        nvShadow[i] <= hostWdata & shadowMask(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= nvShadow;
    end else begin
      for (int i = 0; i < SHADOW_CNT; i++) begin
        if (ctl.shadowWr && ctl.shadowIdx == SHADOW_IDX_W'(i))
          shadow[i] <= hostWdata & shadowMask(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             scratch <= '0;
    else if (ctl.scratchWr) scratch[ctl.scratchIdx] <= hostWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinMeta <= '0;
      pinSync <= '0;
    end else begin
      pinMeta <= pinIn;
      pinSync <= pinMeta;
    end
  end

  always_comb begin
    unique case (ctl.rdSel)
      RD_USER:    rdNext = nvUser[ctl.userIdx];
      RD_SHADOW:  rdNext = shadow[ctl.shadowIdx];
      RD_STATUS:  rdNext = ctl.statusIdx ? DATA_W'(pinSync[PIN_CNT-1]) : pinSync[DATA_W-1:0];
      RD_SCRATCH: rdNext = scratch[ctl.scratchIdx];
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         hostRdata <= '0;
    else if (ctl.rdEn) hostRdata <= rdNext;
  end

  assign cfgProtect = shadow[SH_CFG][0];
  assign pullUpEn   = {shadow[SH_PULLUP_HI][0], shadow[SH_PULLUP_LO]};
  assign pullDownEn = ~{shadow[SH_DRIVE_HI][0], shadow[SH_DRIVE_LO]};

  AST_PROTECT_SHADOW_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shadowWr && !ctl.nvWr) |=> $stable(nvShadow)); // R5
  AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shadowWr |=> $stable(shadow)); // R5
  AST_RESET_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (shadow == nvShadow)); // R6
  AST_SCRATCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.scratchWr |=> $stable(scratch)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.rdEn |=> $stable(hostRdata)); // R11

endmodule

// File: rtl/ioxRegBank.sv
module ioxRegBank
  import ioxRegPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         strapAddr,
  output logic [6:0]         devAddr,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [DATA_W-1:0]  hostWdata,
  input  logic               hostWr,
  input  logic               hostRd,
  output logic [DATA_W-1:0]  hostRdata,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic [PIN_CNT-1:0] pullUpEn,
  output logic [PIN_CNT-1:0] pullDownEn
);

  ctlStrobe_t ctl;
  logic       cfgProtect;

  assign devAddr = {4'b1010, strapAddr};

  ioxRegCtrl u_ctrl (
    .hostAddr   (hostAddr),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .cfgProtect (cfgProtect),
    .ctl        (ctl)
  );

  ioxRegData u_data (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .hostWdata  (hostWdata),
    .pinIn      (pinIn),
    .hostRdata  (hostRdata),
    .pullUpEn   (pullUpEn),
    .pullDownEn (pullDownEn),
    .cfgProtect (cfgProtect)
  );

endmodule

// File: tb/ioxRegBank_bench.sv
`timescale 1ns/1ps
module ioxRegBank_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] strapAddr = '0;
  logic [6:0] devAddr;
  logic [7:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic       hostWr = 1'b0;
  logic       hostRd = 1'b0;
  logic [7:0] hostRdata;
  logic [8:0] pinIn = '0;
  logic [8:0] pullUpEn;
  logic [8:0] pullDownEn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ioxRegBank u_ioxRegBank (
    .clk(clk), .rstN(rstN), .strapAddr(strapAddr), .devAddr(devAddr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostWr(hostWr), .hostRd(hostRd),
    .hostRdata(hostRdata), .pinIn(pinIn), .pullUpEn(pullUpEn), .pullDownEn(pullDownEn)
  );

  // Behavioural reference model
  logic [7:0] mLive [256];
  logic [7:0] mPersist [256];
  logic [7:0] mRdata = '0;
  logic [8:0] pinHist [$];
  bit         started = 0;

  initial begin
    for (int a = 0; a < 256; a++) begin
      mLive[a] = '0;
      mPersist[a] = '0;
    end
    mPersist[8'hF2] = 8'hFF;
    mPersist[8'hF3] = 8'h01;
  end

  function automatic logic [8:0] mStatus();
    return (pinHist.size() == 2) ? pinHist[0] : 9'h0;
  endfunction

  function automatic logic [7:0] mRead(logic [7:0] a);
    if (a < 8'h40) return mPersist[a];
    if (a < 8'hF0) return 8'h00;
    if (a < 8'hF5) return mLive[a];
    if (a < 8'hF8) return mPersist[a];
    if (a == 8'hF8) return mStatus() & 9'hFF;
    if (a == 8'hF9) return {7'b0, mStatus() >> 8};
    return mLive[a];
  endfunction

  function automatic void mWrite(logic [7:0] a, logic [7:0] d);
    logic [7:0] m;
    if (a < 8'h40 || (a >= 8'hF5 && a < 8'hF8)) mPersist[a] = d;
    else if (a >= 8'hF0 && a < 8'hF5) begin
      m = (a == 8'hF1 || a == 8'hF3 || a == 8'hF4) ? 8'h01 : 8'hFF;
      if (!mLive[8'hF4][0]) mPersist[a] = d & m;
      mLive[a] = d & m;
    end else if (a >= 8'hFA) mLive[a] = d;
  endfunction

  always @(posedge clk) begin
    logic [7:0] nextR;
    started = 1;
    if (!rstN) begin
      for (int a = 8'hF0; a < 8'hF5; a++) mLive[a] = mPersist[a];
      for (int a = 8'hFA; a < 256; a++) mLive[a] = 8'h00;
      mRdata = 8'h00;
      pinHist.delete();
    end else begin
      nextR = hostRd ? mRead(hostAddr) : mRdata;
      if (hostWr) mWrite(hostAddr, hostWdata);
      pinHist.push_back(pinIn);
      if (pinHist.size() > 2) void'(pinHist.pop_front());
      mRdata = nextR;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (started) begin
      check("R11 rdata vs model", 16'(hostRdata), 16'(mRdata));
      check("R3 pullUpEn vs model", 16'(pullUpEn), 16'({mLive[8'hF1][0], mLive[8'hF0]}));
      check("R4 pullDownEn vs model", 16'(pullDownEn), 16'(~{mLive[8'hF3][0], mLive[8'hF2]} & 9'h1FF));
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rdCheck(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    check(tag, 16'(hostRdata), 16'(exp));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state
    check("R11 rdata after reset", 16'(hostRdata), 16'h0);
    check("R3 pullUpEn default", 16'(pullUpEn), 16'h0);
    check("R4 pullDownEn default", 16'(pullDownEn), 16'h0);
    rdCheck(8'h00, 8'h00, "R1 user default");
    rdCheck(8'hF2, 8'hFF, "R4 F2 default");
    rdCheck(8'hF3, 8'h01, "R4 F3 default");

    // User memory
    wr(8'h00, 8'h11);
    wr(8'h3F, 8'h22);
    rdCheck(8'h00, 8'h11, "R1 user 0x00");
    rdCheck(8'h3F, 8'h22, "R1 user 0x3F");

    // Pullup and pulldown
    wr(8'hF0, 8'hA5);
    wr(8'hF1, 8'hFF);
    rdCheck(8'hF1, 8'h01, "R3 F1 upper bits zero");
    check("R3 pullUpEn", 16'(pullUpEn), 16'h1A5);
    wr(8'hF2, 8'h3C);
    wr(8'hF3, 8'hFE);
    rdCheck(8'hF3, 8'h00, "R4 F3 masked");
    check("R4 pullDownEn", 16'(pullDownEn), 16'h1C3);

    // Protect on (written to both copies), then shadow-only write
    wr(8'hF4, 8'hFF);
    rdCheck(8'hF4, 8'h01, "R4 F4 upper bits zero");
    wr(8'hF0, 8'h0F);
    check("R5 shadow write visible", 16'(pullUpEn), 16'h10F);
    wr(8'h10, 8'h33);
    rdCheck(8'h10, 8'h33, "R1 user write under protect");
    doReset();
    rdCheck(8'hF0, 8'hA5, "R6 shadow restored from persistent");
    rdCheck(8'hF4, 8'h01, "R6 protect persisted");
    check("R6 pulldown restored", 16'(pullDownEn), 16'h1C3);
    rdCheck(8'h3F, 8'h22, "R6 user survives reset");

    // Clear protect (shadow only), then a write reaching both copies
    wr(8'hF4, 8'h00);
    wr(8'hF1, 8'h00);
    doReset();
    rdCheck(8'hF4, 8'h01, "R5 protect clear was shadow only");
    rdCheck(8'hF1, 8'h00, "R5 unprotected write persisted");

    // High user bytes
    wr(8'hF5, 8'h5A);
    wr(8'hF7, 8'hC3);
    rdCheck(8'hF5, 8'h5A, "R7 user 0xF5");
    rdCheck(8'hF7, 8'hC3, "R7 user 0xF7");

    // Reserved ranges
    wr(8'h40, 8'h55);
    wr(8'hE7, 8'h66);
    wr(8'hE8, 8'h77);
    wr(8'hEF, 8'h88);
    rdCheck(8'h40, 8'h00, "R2 reserved 0x40");
    rdCheck(8'hE7, 8'h00, "R2 reserved 0xE7");
    rdCheck(8'hE8, 8'h00, "R2 reserved 0xE8");
    rdCheck(8'hEF, 8'h00, "R2 reserved 0xEF");
    rdCheck(8'h00, 8'h11, "R2 no alias into user");

    // Pin status
    @(negedge clk);
    pinIn = 9'h1A5;
    repeat (3) @(negedge clk);
    rdCheck(8'hF8, 8'hA5, "R8 status low");
    rdCheck(8'hF9, 8'h01, "R8 status pin 8");
    wr(8'hF8, 8'h00);
    rdCheck(8'hF8, 8'hA5, "R8 status write ignored");
    @(negedge clk);
    pinIn = 9'h05A;
    repeat (3) @(negedge clk);
    rdCheck(8'hF9, 8'h00, "R8 status pin 8 low");

    // Scratch
    wr(8'hFA, 8'h77);
    wr(8'hFF, 8'h88);
    rdCheck(8'hFA, 8'h77, "R9 scratch 0xFA");
    rdCheck(8'hFF, 8'h88, "R9 scratch 0xFF");
    doReset();
    rdCheck(8'hFA, 8'h00, "R9 scratch cleared");
    rdCheck(8'hFF, 8'h00, "R9 scratch cleared");

    // Device address
    @(negedge clk);
    strapAddr = 3'b101;
    #1 check("R10 devAddr 101", 16'(devAddr), 16'h55);
    strapAddr = 3'b000;
    #1 check("R10 devAddr 000", 16'(devAddr), 16'h50);

    // Same-cycle read and write returns the old value, then holds
    @(negedge clk);
    hostAddr = 8'h20; hostWdata = 8'h5A; hostWr = 1'b1; hostRd = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostRd = 1'b0;
    check("R11 read before write", 16'(hostRdata), 16'h00);
    repeat (3) @(negedge clk);
    check("R11 rdata holds", 16'(hostRdata), 16'h00);
    rdCheck(8'h20, 8'h5A, "R11 new value after write");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule